// File: doc/BRIEF.md
# Register Bank Save-Restore Controller

This block keeps a small bank of byte-wide configuration registers and copies that bank to a byte-wide nonvolatile store of 512 bytes, or back from it. A host reads and writes the registers over a simple synchronous register port. The host starts a save by setting an enable bit, arming the register-to-store direction and then writing an update strobe. A restore starts on a reset event when a strap pin is high, or when the host writes a self-clearing load bit. When the strap is low, a reset leaves the registers at their computed default values.

While bytes are moving, the block locks out the host. Every write is dropped, and every read except the busy status register is refused. A status pin can be set to follow the busy state. An error bit reports a transfer that stopped because the store failed to answer with ready. After each transfer the block enforces a minimum gap before the next one. A request made during the gap waits and then runs.

Top module: `cfg_nv_keeper`

## Requirements
- R1: With the strap low, reset leaves busy at 0 and sets configuration register i (host address i, 0 <= i < NREG) to 0x5A XOR ((i*0x13) mod 256). No transfer runs.
- R2: Writing 1 to bit 0 of the update register (0xF2) starts a save only if bit 0 of the control register (0xF0, save enable) and bit 0 of the command register (0xF1, store direction armed) are both 1. A save copies register i to store byte i for i from 0 to NREG-1. Otherwise the strobe has no effect.
- R3: When a save completes, bit 0 of the command register returns to 0 without any host write.
- R4: Bit 0 of the status register (0xF3) and the busy output are 1 during a transfer and 0 otherwise. The status pin equals busy when bit 2 of the command register is 1, and is 0 otherwise.
- R5: During a transfer, host writes are dropped. Host reads of any address other than 0xF3 return 0 and raise the refused flag. A read of 0xF3 returns 1 and does not raise the flag.
- R6: If the store does not give ready within RDY_TIMEOUT cycles of a byte request, the transfer stops and bit 0 of the error register (0xF4) reads 1. The next transfer clears it, and it stays 0 if that transfer succeeds.
- R7: With the strap high, a hardware reset first loads the defaults and then restores register i from store byte i.
- R8: Writing 1 to bit 1 of the command register is a soft reset and reads back as 0. It reloads the defaults and clears the control and command bits. A restore follows only if the strap is high.
- R9: Writing 1 to bit 1 of the control register starts a restore whatever the strap level. That bit reads back as 0.
- R10: After a transfer ends, no transfer starts for at least GAP_CYCLES cycles. A request made in that window runs after the window ends.
- R11: The memory port asserts write strobe only for saves and read strobe only for restores, never both at once, and moves one byte per ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_nv | input | 1 | Restore-on-reset strap |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid the cycle after a read |
| host_refused | output | 1 | Access refused, the cycle after the request |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Last transfer failed |
| status_pin | output | 1 | Busy when selected, else 0 |
| mem_addr | output | 9 | Store byte address |
| mem_wdata | output | 8 | Store write data |
| mem_we | output | 1 | Store write strobe |
| mem_re | output | 1 | Store read strobe |
| mem_rdata | input | 8 | Store read data |
| mem_rdy | input | 1 | Store ready for the current byte |

## Verification
Save and restore round trips are run with four bank patterns: a constant zero, a constant all-ones, an incrementing ramp and alternating 0x55/0xAA. The constant patterns expose stuck data bits. The ramp exposes address or ordering slips between register index and store byte. The alternating pattern exposes mixing between neighbouring bytes. Each pattern uses a different store latency, which separates correct ready pacing from a design that advances without waiting. Directed cases then cover strobes with a missing enable bit, host lockout, a dead store, strap-driven reset restore and a request placed inside the gap.

// File: rtl/nvk_pkg.sv
package nvk_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_XFER, SQ_GAP} sq_state_t;

  localparam logic [7:0] A_CTRL = 8'hF0;
  localparam logic [7:0] A_CMD  = 8'hF1;
  localparam logic [7:0] A_UPD  = 8'hF2;
  localparam logic [7:0] A_STAT = 8'hF3;
  localparam logic [7:0] A_ERR  = 8'hF4;

  function automatic logic [7:0] dflt_byte(int unsigned i);
    return 8'h5A ^ 8'(i * 19);
  endfunction
endpackage

// File: rtl/nvk_host_regs.sv
module nvk_host_regs
  import nvk_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             host_refused,
  input  logic             busy,
  input  logic             err,
  input  logic             rst_we,
  input  logic [IDX_W-1:0] rst_idx,
  input  logic [7:0]       rst_data,
  input  logic [IDX_W-1:0] sv_idx,
  output logic [7:0]       sv_data,
  input  logic             save_done,
  output logic             save_req,
  output logic             load_req,
  output logic             soft_rst,
  output logic             arm_o,
  output logic             sel_o
);
  logic [7:0] regs_q [NREG];
  logic       wr_en_q, arm_q, sel_q;
  logic [7:0] rd_mux;
  logic       is_cfg;

  assign is_cfg  = (host_addr < 8'(NREG));
  assign sv_data = regs_q[sv_idx];
  assign arm_o   = arm_q;
  assign sel_o   = sel_q;

  always_comb begin
    rd_mux = 8'h00;
    if (is_cfg) rd_mux = regs_q[host_addr[IDX_W-1:0]];
    else begin
      case (host_addr)
        A_CTRL: rd_mux = {7'b0, wr_en_q};
        A_CMD:  rd_mux = {5'b0, sel_q, 1'b0, arm_q};
        A_STAT: rd_mux = {7'b0, busy};
        A_ERR:  rd_mux = {7'b0, err};
        default: rd_mux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= dflt_byte(i);
      wr_en_q <= 1'b0; arm_q <= 1'b0; sel_q <= 1'b0;
      host_rdata <= 8'h00; host_refused <= 1'b0;
      save_req <= 1'b0; load_req <= 1'b0; soft_rst <= 1'b0;
    end else begin
      save_req <= 1'b0; load_req <= 1'b0; soft_rst <= 1'b0;
      host_rdata <= 8'h00; host_refused <= 1'b0;
      if (rst_we) regs_q[rst_idx] <= rst_data;
      if (save_done) arm_q <= 1'b0;
      if (busy) begin
        if (host_rd) begin
          if (host_addr == A_STAT) host_rdata <= 8'h01;
          else host_refused <= 1'b1;
        end
        if (host_wr) host_refused <= 1'b1;
      end else begin
        if (host_rd) host_rdata <= rd_mux;
        if (host_wr) begin
          if (is_cfg) regs_q[host_addr[IDX_W-1:0]] <= host_wdata;
          else begin
            case (host_addr)
              A_CTRL: begin
                wr_en_q <= host_wdata[0];
                if (host_wdata[1]) load_req <= 1'b1;
              end
              A_CMD: begin
                arm_q <= host_wdata[0];
                sel_q <= host_wdata[2];
                if (host_wdata[1]) begin
                  soft_rst <= 1'b1;
                  for (int i = 0; i < NREG; i++) regs_q[i] <= dflt_byte(i);
                  wr_en_q <= 1'b0; arm_q <= 1'b0; sel_q <= 1'b0;
                end
              end
              A_UPD: if (host_wdata[0] && wr_en_q && arm_q) save_req <= 1'b1;
              default: ;
            endcase
          end
        end
      end
    end
  end

  AST_LOCK_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (busy && host_rd && host_addr != A_STAT) |=> host_refused); // R5
endmodule

// File: rtl/nvk_seq.sv
module nvk_seq
  import nvk_pkg::*;
#(
  parameter int NREG        = 16,
  parameter int STORE_BYTES = 512,
  parameter int GAP_CYCLES  = 24,
  parameter int RDY_TIMEOUT = 12,
  parameter int IDX_W       = $clog2(NREG),
  parameter int MA_W        = $clog2(STORE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap,
  input  logic             save_req,
  input  logic             load_req,
  input  logic             soft_rst,
  input  logic [7:0]       sv_data,
  output logic [IDX_W-1:0] sv_idx,
  output logic             rst_we,
  output logic [IDX_W-1:0] rst_idx,
  output logic [7:0]       rst_data,
  output logic             save_done,
  output logic             busy,
  output logic             err,
  output logic             dir_save,
  output logic [MA_W-1:0]  mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             mem_we,
  output logic             mem_re,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_rdy
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam int TW = $clog2(RDY_TIMEOUT + 1);

  sq_state_t      st_q;
  logic [MA_W:0]  idx_q;
  logic [TW-1:0]  wait_q;
  logic [GW-1:0]  gap_q;
  logic           pend_ld, pend_sv;
  logic           ovf, last, xfer;

  assign xfer      = (st_q == SQ_XFER);
  assign ovf       = (idx_q >= (MA_W+1)'(STORE_BYTES));
  assign last      = (idx_q == (MA_W+1)'(NREG - 1));
  assign busy      = xfer;
  assign sv_idx    = idx_q[IDX_W-1:0];
  assign rst_idx   = idx_q[IDX_W-1:0];
  assign rst_data  = mem_rdata;
  assign mem_addr  = idx_q[MA_W-1:0];
  assign mem_wdata = sv_data;
  assign mem_we    = xfer && dir_save && !ovf;
  assign mem_re    = xfer && !dir_save && !ovf;
  assign rst_we    = mem_re && mem_rdy;
  assign save_done = mem_we && mem_rdy && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SQ_IDLE; idx_q <= '0; wait_q <= '0; gap_q <= '0;
      pend_ld <= strap; pend_sv <= 1'b0; err <= 1'b0; dir_save <= 1'b0;
    end else begin
      if (soft_rst) pend_sv <= 1'b0;
      case (st_q)
        SQ_IDLE: if (pend_ld || pend_sv) begin
          st_q <= SQ_XFER; dir_save <= !pend_ld;
          if (pend_ld) pend_ld <= 1'b0; else pend_sv <= 1'b0;
          idx_q <= '0; wait_q <= '0; err <= 1'b0;
        end
        SQ_XFER: begin
          if (ovf) begin
            err <= 1'b1; st_q <= SQ_GAP; gap_q <= GW'(GAP_CYCLES - 1);
          end else if (mem_rdy) begin
            wait_q <= '0;
            if (last) begin
              st_q <= SQ_GAP; gap_q <= GW'(GAP_CYCLES - 1);
            end else idx_q <= idx_q + 1'b1;
          end else if (wait_q == TW'(RDY_TIMEOUT - 1)) begin
            err <= 1'b1; st_q <= SQ_GAP; gap_q <= GW'(GAP_CYCLES - 1);
          end else wait_q <= wait_q + 1'b1;
        end
        SQ_GAP: if (gap_q == '0) st_q <= SQ_IDLE; else gap_q <= gap_q - 1'b1;
        default: st_q <= SQ_IDLE;
      endcase
      if (soft_rst && strap) pend_ld <= 1'b1;
      if (load_req) pend_ld <= 1'b1;
      if (save_req) pend_sv <= 1'b1;
    end
  end

  // checker state: cycles spent idle since the last transfer
  logic          seen_end;
  logic [GW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_end <= 1'b0; since_q <= '0;
    end else if (busy) begin
      seen_end <= 1'b1; since_q <= '0;
    end else if (since_q < GW'(GAP_CYCLES)) since_q <= since_q + 1'b1;
  end

  AST_GAP_RESPECTED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!seen_end || since_q >= GW'(GAP_CYCLES))); // R10
  AST_ERR_CLEAR_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !err); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)); // R11
endmodule

// File: rtl/cfg_nv_keeper.sv
module cfg_nv_keeper #(
  parameter int NREG        = 16,
  parameter int STORE_BYTES = 512,
  parameter int GAP_CYCLES  = 24,
  parameter int RDY_TIMEOUT = 12,
  localparam int IDX_W      = $clog2(NREG),
  localparam int MA_W       = $clog2(STORE_BYTES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strap_nv,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [7:0]      host_addr,
  input  logic [7:0]      host_wdata,
  output logic [7:0]      host_rdata,
  output logic            host_refused,
  output logic            busy_o,
  output logic            err_o,
  output logic            status_pin,
  output logic [MA_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  input  logic [7:0]      mem_rdata,
  input  logic            mem_rdy
);
  logic [IDX_W-1:0] sv_idx, rst_idx;
  logic [7:0]       sv_data, rst_data;
  logic             rst_we, save_done, save_req, load_req, soft_rst;
  logic             busy, err, dir_save, arm, sel;

  nvk_host_regs #(.NREG(NREG), .IDX_W(IDX_W)) u_regs (
    .clk, .rst, .host_wr, .host_rd, .host_addr, .host_wdata,
    .host_rdata, .host_refused, .busy, .err,
    .rst_we, .rst_idx, .rst_data, .sv_idx, .sv_data, .save_done,
    .save_req, .load_req, .soft_rst, .arm_o(arm), .sel_o(sel)
  );

  nvk_seq #(.NREG(NREG), .STORE_BYTES(STORE_BYTES), .GAP_CYCLES(GAP_CYCLES),
            .RDY_TIMEOUT(RDY_TIMEOUT), .IDX_W(IDX_W), .MA_W(MA_W)) u_seq (
    .clk, .rst, .strap(strap_nv), .save_req, .load_req, .soft_rst,
    .sv_data, .sv_idx, .rst_we, .rst_idx, .rst_data, .save_done,
    .busy, .err, .dir_save, .mem_addr, .mem_wdata, .mem_we, .mem_re,
    .mem_rdata, .mem_rdy
  );

  assign busy_o     = busy;
  assign err_o      = err;
  assign status_pin = sel && busy;

  AST_ARM_CLEARED: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && dir_save && !err) |-> !arm); // R3
endmodule

// File: tb/test_cfg_nv_keeper.sv
module test_cfg_nv_keeper;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;
  localparam int GAP = 24;
  localparam int TMO = 12;

  logic clk = 1'b0, rst = 1'b1, strap = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0, host_rdata, mem_wdata, mem_rdata;
  logic host_refused, busy_o, err_o, status_pin, mem_we, mem_re, mem_rdy;
  logic [8:0] mem_addr;

  int n_chk = 0, n_fail = 0, lat = 0, lat_cnt = 0, both_seen = 0;
  bit dead = 1'b0, done = 1'b0;
  logic [7:0] store [512];
  logic [7:0] pat_q [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_nv_keeper #(.NREG(NREG), .GAP_CYCLES(GAP), .RDY_TIMEOUT(TMO)) i_cfg_nv_keeper (
    .clk, .rst, .strap_nv(strap), .host_wr, .host_rd, .host_addr, .host_wdata,
    .host_rdata, .host_refused, .busy_o, .err_o, .status_pin,
    .mem_addr, .mem_wdata, .mem_we, .mem_re, .mem_rdata, .mem_rdy
  );

  assign mem_rdy   = (mem_we || mem_re) && !dead && (lat_cnt == lat);
  assign mem_rdata = store[mem_addr];
  always @(posedge clk) begin
    if (mem_we && mem_re) both_seen <= both_seen + 1;
    if (mem_we || mem_re) begin
      lat_cnt <= (lat_cnt == lat) ? 0 : lat_cnt + 1;
      if (mem_we && mem_rdy) store[mem_addr] <= mem_wdata;
    end else lat_cnt <= 0;
  end

  // vector: {kind[1:0], base[7:0], latency[3:0]}
  localparam logic [13:0] VEC [4] = '{
    {2'd0, 8'h00, 4'd0}, {2'd0, 8'hFF, 4'd2},
    {2'd1, 8'h10, 4'd1}, {2'd2, 8'h55, 4'd3}};

  function automatic logic [7:0] pat(logic [1:0] k, logic [7:0] b, int i);
    if (k == 2'd1) return b + 8'(i);
    if (k == 2'd2) return i[0] ? ~b : b;
    return b;
  endfunction

  function automatic logic [7:0] dflt(int i);
    return 8'h5A ^ 8'(i * 19);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d, output logic rf);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0; d = host_rdata; rf = host_refused;
  endtask

  task automatic wait_xfer(output bit started);
    int n = 0;
    started = 1'b0;
    while (!busy_o && n < 40) begin @(negedge clk); n++; end
    started = busy_o;
    while (busy_o && n < 5000) begin @(negedge clk); n++; end
    repeat (GAP + 4) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d; logic rf; bit st; int cnt;
    for (int i = 0; i < 512; i++) store[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    for (int i = 0; i < NREG; i++) begin
      rd(8'(i), d, rf);
      chk(d == dflt(i), "R1 default", d, dflt(i));
    end
    chk(err_o == 1'b0, "R6 err at reset", err_o, 0);

    // table: save then restore round trip per pattern (R2, R3, R9)
    for (int v = 0; v < 4; v++) begin
      lat = int'(VEC[v][3:0]);
      for (int i = 0; i < NREG; i++) begin
        pat_q[i] = pat(VEC[v][13:12], VEC[v][11:4], i);
        wr(8'(i), pat_q[i]);
      end
      wr(8'hF0, 8'h01); wr(8'hF1, 8'h01); wr(8'hF2, 8'h01);
      wait_xfer(st);
      chk(st, "R2 save started", st, 1);
      for (int i = 0; i < NREG; i++)
        chk(store[i] == pat_q[i], "R2 store byte", store[i], pat_q[i]);
      rd(8'hF1, d, rf);
      chk(d[0] == 1'b0, "R3 arm cleared", d, 0);
      for (int i = 0; i < NREG; i++) wr(8'(i), ~pat_q[i]);
      wr(8'hF0, 8'h02);
      wait_xfer(st);
      for (int i = 0; i < NREG; i++) begin
        rd(8'(i), d, rf);
        chk(d == pat_q[i], "R9 restored byte", d, pat_q[i]);
      end
      rd(8'hF0, d, rf);
      chk(d[1] == 1'b0, "R9 load bit self-clears", d, 0);
      rd(8'hF4, d, rf);
      chk(d[0] == 1'b0, "R6 no error", d, 0);
    end

    // R2: strobe without enable or without arm is ignored
    wr(8'h00, 8'hC3);
    wr(8'hF0, 8'h00); wr(8'hF1, 8'h01); wr(8'hF2, 8'h01);
    wait_xfer(st);
    chk(!st, "R2 no save without enable", st, 0);
    wr(8'hF0, 8'h01); wr(8'hF1, 8'h00); wr(8'hF2, 8'h01);
    wait_xfer(st);
    chk(!st, "R2 no save without arm", st, 0);
    chk(store[0] == pat_q[0], "R2 store untouched", store[0], pat_q[0]);

    // R4 R5 R10: lockout during a slow save, then a load placed in the gap
    lat = 6;
    wr(8'hF0, 8'h01); wr(8'hF1, 8'h05); wr(8'hF2, 8'h01);
    cnt = 0;
    while (!busy_o && cnt < 20) begin @(negedge clk); cnt++; end
    chk(busy_o && status_pin, "R4 busy and pin", {busy_o, status_pin}, 3);
    rd(8'hF3, d, rf);
    chk(d == 8'h01 && !rf, "R5 status read allowed", {rf, d}, 1);
    rd(8'h00, d, rf);
    chk(d == 8'h00 && rf, "R5 read refused", {rf, d}, 9'h100);
    wr(8'h00, 8'hEE);
    while (busy_o) @(negedge clk);
    chk(status_pin == 1'b0, "R4 pin low when idle", status_pin, 0);
    wr(8'hF0, 8'h02);
    cnt = 2;
    while (!busy_o && cnt < 200) begin @(negedge clk); cnt++; end
    chk(cnt >= GAP && cnt < GAP + 6, "R10 gap then pending load", cnt, GAP);
    wait_xfer(st);
    rd(8'h00, d, rf);
    chk(d == 8'hC3, "R5 write during busy dropped", d, 8'hC3);

    // R6: dead store times out
    lat = 0; dead = 1'b1;
    wr(8'hF0, 8'h02);
    wait_xfer(st);
    rd(8'hF4, d, rf);
    chk(d[0] == 1'b1, "R6 timeout error", d, 1);
    dead = 1'b0;
    wr(8'hF0, 8'h02);
    wait_xfer(st);
    rd(8'hF4, d, rf);
    chk(d[0] == 1'b0, "R6 error cleared", d, 0);

    // R7: strap high reset restores from store
    strap = 1'b1;
    for (int i = 0; i < NREG; i++) store[i] = 8'(i * 7 + 3);
    @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    wait_xfer(st);
    chk(st, "R7 restore on reset", st, 1);
    for (int i = 0; i < NREG; i++) begin
      rd(8'(i), d, rf);
      chk(d == 8'(i * 7 + 3), "R7 restored byte", d, i * 7 + 3);
    end

    // R8: soft reset with strap high then low
    wr(8'h05, 8'h99); wr(8'hF0, 8'h01);
    wr(8'hF1, 8'h02);
    wait_xfer(st);
    rd(8'h05, d, rf);
    chk(st && d == 8'(38), "R8 soft reset restores", d, 38);
    rd(8'hF0, d, rf);
    chk(d == 8'h00, "R8 control cleared", d, 0);
    strap = 1'b0;
    wr(8'h05, 8'h99);
    wr(8'hF1, 8'h02);
    wait_xfer(st);
    rd(8'h05, d, rf);
    chk(!st && d == dflt(5), "R8 soft reset defaults", d, dflt(5));
    rd(8'hF1, d, rf);
    chk(d == 8'h00, "R8 command reads 0", d, 0);

    chk(both_seen == 0, "R11 strobes exclusive", both_seen, 0);
    summary();
  end
endmodule